// File: doc/BRIEF.md
# Systolic Result Store Unit

This block sits between a 3x3 output-stationary systolic array and the data memory of a matrix accelerator. When the sequencer issues a collect command, the unit opens its array-facing valid/ready stream. It captures the nine result elements into a local buffer in the order they arrive. It closes the stream once the buffer is full.

A later write command makes the unit take the destination base address from the accelerator's result-address register. The unit then drains the buffer through a wide memory port, three 32-bit words per request, at byte addresses base, base+12 and base+24. It counts the write responses, and the third response produces a one-cycle done pulse back to the sequencer. Collection and writeback are separate phases. Memory stalls never back up into the array, and the array never waits on memory.

Top module: `result_store_unit`

## Requirements
- R1: A one-cycle pulse on `collect_i` restarts collection. From the next cycle `strm_ready_o` is high, and the next accepted element goes to slot 0. A new collect replaces the previous buffer contents.
- R2: While `strm_ready_o` is high, each cycle with `strm_valid_i` high stores `strm_data_i` into the next free slot, in arrival order. Idle cycles between elements are allowed.
- R3: In the cycle after the ninth element is captured, `strm_ready_o` is low. It stays low until the next collect, and data offered meanwhile does not change the buffer.
- R4: A one-cycle pulse on `write_i` samples `res_base_i` in that cycle. Exactly three write requests follow, at byte addresses base, base+12 and base+24, in that order.
- R5: The request for beat k (k = 0, 1, 2) carries slot 3k in `mreq_data_o[31:0]`, slot 3k+1 in bits [63:32] and slot 3k+2 in bits [95:64].
- R6: A request is taken only in a cycle where `mreq_valid_o` and `mreq_ready_i` are both high. While `mreq_ready_i` is low, the valid, address and data outputs hold steady.
- R7: `done_o` is a single-cycle pulse in the cycle after the third write response is accepted. Accepted requests alone never raise it.
- R8: While reset is asserted, and at release, `strm_ready_o`, `mreq_valid_o` and `done_o` are low.
- R9: A response that arrives while no write sequence is in progress is ignored and does not produce `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| collect_i | input | 1 | Collect command pulse from the sequencer |
| write_i | input | 1 | Write command pulse from the sequencer |
| res_base_i | input | 32 | Result base byte address from the accelerator register bank |
| strm_valid_i | input | 1 | Result element valid from the array |
| strm_data_i | input | 32 | Result element from the array |
| strm_ready_o | output | 1 | Ready toward the array |
| mreq_valid_o | output | 1 | Memory write request valid |
| mreq_ready_i | input | 1 | Memory write request ready |
| mreq_addr_o | output | 32 | Byte address of the three-word request |
| mreq_data_o | output | 96 | Three 32-bit words, lowest slot in the low bits |
| mresp_valid_i | input | 1 | Memory write response valid |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: 32-bit elements, nine buffer slots and three words per request. These values cover the full 3x3 case, so the last buffer slot, the ready drop after the ninth element, and the third-response completion are all reached. Requests are tried both against a memory that accepts at once and against one that stalls each beat. That makes the hold rule and the address stepping observable. The elements are fed back-to-back and with gaps, and a second collect with new data shows that the buffer is replaced.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_SEND = 2'd1,
    DR_WAIT = 2'd2
  } drain_state_e;
endpackage

// File: rtl/rsu_rst_sync.sv
module rsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rsu_collect.sv
module rsu_collect #(
  parameter int ELEM_W    = 32,
  parameter int NUM_ELEMS = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        collect_i,
  input  logic                        valid_i,
  input  logic [ELEM_W-1:0]           data_i,
  output logic                        ready_o,
  output logic [NUM_ELEMS*ELEM_W-1:0] buf_o
);
  localparam int CNT_W = $clog2(NUM_ELEMS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             cap;

  // a collect in the same cycle takes priority over a capture
  assign cap     = valid_i & open_q & ~collect_i;
  assign ready_o = open_q;

  always_comb begin
    cnt_d  = cnt_q;
    open_d = open_q;
    if (collect_i) begin
      cnt_d  = '0;
      open_d = 1'b1;
    end else if (cap) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_ELEMS - 1)) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      open_q <= open_d;
    end
  end

  // one enabled data register per slot, no reset on the data path
  for (genvar g = 0; g < NUM_ELEMS; g++) begin : g_slot
    logic              slot_en;
    logic [ELEM_W-1:0] slot_q;

    assign slot_en = cap & (cnt_q == CNT_W'(g));

    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= data_i;
    end

    assign buf_o[g*ELEM_W +: ELEM_W] = slot_q;
  end
endmodule

// File: rtl/rsu_drain.sv
module rsu_drain
  import rsu_pkg::*;
#(
  parameter int ELEM_W     = 32,
  parameter int NUM_ELEMS  = 9,
  parameter int BEAT_ELEMS = 3,
  parameter int ADDR_W     = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            write_i,
  input  logic [ADDR_W-1:0]               base_i,
  input  logic [NUM_ELEMS*ELEM_W-1:0]     buf_i,
  output logic                            req_valid_o,
  input  logic                            req_ready_i,
  output logic [ADDR_W-1:0]               req_addr_o,
  output logic [BEAT_ELEMS*ELEM_W-1:0]    req_data_o,
  input  logic                            resp_valid_i,
  output logic                            done_o
);
  localparam int BEATS      = NUM_ELEMS / BEAT_ELEMS;
  localparam int BEAT_W     = BEAT_ELEMS * ELEM_W;
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1;

  drain_state_e      state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  rcnt_q, rcnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              req_fire, resp_fire;
  logic [BEAT_W-1:0] beats [BEATS];

  assign req_valid_o = (state_q == DR_SEND);
  assign req_fire    = req_valid_o & req_ready_i;
  assign resp_fire   = resp_valid_i & (state_q != DR_IDLE);
  assign req_addr_o  = addr_q;
  assign done_o      = done_q;

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beats[g] = buf_i[g*BEAT_W +: BEAT_W];
  end

  always_comb begin
    req_data_o = '0;
    for (int b = 0; b < BEATS; b++) begin
      if (idx_q == IDX_W'(b)) req_data_o = beats[b];
    end
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rcnt_d  = rcnt_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    if (write_i) begin
      state_d = DR_SEND;
      idx_d   = '0;
      rcnt_d  = '0;
      addr_d  = base_i;
    end else begin
      if (req_fire) begin
        idx_d  = idx_q + 1'b1;
        addr_d = addr_q + ADDR_W'(BEAT_BYTES);
        if (idx_q == IDX_W'(BEATS - 1)) state_d = DR_WAIT;
      end
      if (resp_fire) begin
        rcnt_d = rcnt_q + 1'b1;
        if (rcnt_q == IDX_W'(BEATS - 1)) begin
          state_d = DR_IDLE;
          done_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DR_IDLE;
      idx_q   <= '0;
      rcnt_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rcnt_q  <= rcnt_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/result_store_unit.sv
module result_store_unit #(
  parameter int ELEM_W     = 32,
  parameter int NUM_ELEMS  = 9,
  parameter int BEAT_ELEMS = 3,
  parameter int ADDR_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         collect_i,
  input  logic                         write_i,
  input  logic [ADDR_W-1:0]            res_base_i,
  input  logic                         strm_valid_i,
  input  logic [ELEM_W-1:0]            strm_data_i,
  output logic                         strm_ready_o,
  output logic                         mreq_valid_o,
  input  logic                         mreq_ready_i,
  output logic [ADDR_W-1:0]            mreq_addr_o,
  output logic [BEAT_ELEMS*ELEM_W-1:0] mreq_data_o,
  input  logic                         mresp_valid_i,
  output logic                         done_o
);
  localparam int BUF_W = NUM_ELEMS * ELEM_W;

  logic             rst_n_int;
  logic [BUF_W-1:0] buf_flat;

  rsu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rsu_collect #(
    .ELEM_W    (ELEM_W),
    .NUM_ELEMS (NUM_ELEMS)
  ) u_collect (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .collect_i (collect_i),
    .valid_i   (strm_valid_i),
    .data_i    (strm_data_i),
    .ready_o   (strm_ready_o),
    .buf_o     (buf_flat)
  );

  rsu_drain #(
    .ELEM_W     (ELEM_W),
    .NUM_ELEMS  (NUM_ELEMS),
    .BEAT_ELEMS (BEAT_ELEMS),
    .ADDR_W     (ADDR_W)
  ) u_drain (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .write_i      (write_i),
    .base_i       (res_base_i),
    .buf_i        (buf_flat),
    .req_valid_o  (mreq_valid_o),
    .req_ready_i  (mreq_ready_i),
    .req_addr_o   (mreq_addr_o),
    .req_data_o   (mreq_data_o),
    .resp_valid_i (mresp_valid_i),
    .done_o       (done_o)
  );
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
  parameter int NUM_ELEMS  = 9,
  parameter int BEATS      = 3,
  parameter int BEAT_BYTES = 12,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              collect_i,
  input logic              write_i,
  input logic              strm_valid_i,
  input logic              strm_ready_o,
  input logic              mreq_valid_o,
  input logic              mreq_ready_i,
  input logic [ADDR_W-1:0] mreq_addr_o,
  input logic [DATA_W-1:0] mreq_data_o,
  input logic              mresp_valid_i,
  input logic              done_o
);
  logic [15:0]       cap_cnt;
  logic [15:0]       req_cnt;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt   <= '0;
      req_cnt   <= '0;
      last_addr <= '0;
    end else begin
      if (collect_i) cap_cnt <= '0;
      else if (strm_valid_i && strm_ready_o) cap_cnt <= cap_cnt + 1'b1;
      if (write_i) req_cnt <= '0;
      else if (mreq_valid_o && mreq_ready_i) begin
        req_cnt   <= req_cnt + 1'b1;
        last_addr <= mreq_addr_o;
      end
    end
  end

  AST_READY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    collect_i |=> strm_ready_o); // R1

  AST_READY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strm_ready_o |-> (cap_cnt < 16'(NUM_ELEMS))); // R3

  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> (req_cnt < 16'(BEATS))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid_o && mreq_ready_i && !write_i && req_cnt != 16'd0)
      |-> (mreq_addr_o == last_addr + ADDR_W'(BEAT_BYTES))); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid_o && !mreq_ready_i && !write_i)
      |=> (mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_data_o))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mresp_valid_i)); // R7
endmodule

bind result_store_unit rsu_checker #(
  .NUM_ELEMS  (NUM_ELEMS),
  .BEATS      (NUM_ELEMS / BEAT_ELEMS),
  .BEAT_BYTES (BEAT_ELEMS * ELEM_W / 8),
  .ADDR_W     (ADDR_W),
  .DATA_W     (BEAT_ELEMS * ELEM_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .collect_i     (collect_i),
  .write_i       (write_i),
  .strm_valid_i  (strm_valid_i),
  .strm_ready_o  (strm_ready_o),
  .mreq_valid_o  (mreq_valid_o),
  .mreq_ready_i  (mreq_ready_i),
  .mreq_addr_o   (mreq_addr_o),
  .mreq_data_o   (mreq_data_o),
  .mresp_valid_i (mresp_valid_i),
  .done_o        (done_o)
);

// File: tb/result_store_unit_test.sv
module result_store_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        collect_i, write_i;
  logic [31:0] res_base_i;
  logic        strm_valid_i;
  logic [31:0] strm_data_i;
  logic        strm_ready_o;
  logic        mreq_valid_o, mreq_ready_i;
  logic [31:0] mreq_addr_o;
  logic [95:0] mreq_data_o;
  logic        mresp_valid_i;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_buf [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  result_store_unit uut (
    .clk(clk), .rst_n(rst_n), .collect_i(collect_i), .write_i(write_i),
    .res_base_i(res_base_i), .strm_valid_i(strm_valid_i), .strm_data_i(strm_data_i),
    .strm_ready_o(strm_ready_o), .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i),
    .mreq_addr_o(mreq_addr_o), .mreq_data_o(mreq_data_o), .mresp_valid_i(mresp_valid_i),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; collect_i = 0; write_i = 0; res_base_i = '0;
    strm_valid_i = 0; strm_data_i = '0; mreq_ready_i = 0; mresp_valid_i = 0;
    repeat (3) @(negedge clk);
    chk(!strm_ready_o && !mreq_valid_o && !done_o, "R8 in reset",
        {strm_ready_o, mreq_valid_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!strm_ready_o && !mreq_valid_o && !done_o, "R8 after release",
        {strm_ready_o, mreq_valid_o, done_o}, 0);
  endtask

  // R1/R2/R3: load nine elements, optionally with idle gaps
  task automatic t_collect(input logic [31:0] seed, input bit gaps);
    collect_i = 1'b1;
    @(negedge clk);
    collect_i = 1'b0;
    chk(strm_ready_o, "R1 ready after collect", strm_ready_o, 1);
    for (int k = 0; k < 9; k++) begin
      if (gaps && (k % 2 == 1)) begin
        strm_valid_i = 1'b0;
        @(negedge clk);
      end
      chk(strm_ready_o, "R2 ready while filling", strm_ready_o, 1);
      exp_buf[k]   = seed ^ (32'h0101_0101 * (k + 1));
      strm_valid_i = 1'b1;
      strm_data_i  = exp_buf[k];
      @(negedge clk);
    end
    strm_valid_i = 1'b0;
    chk(!strm_ready_o, "R3 ready low after ninth", strm_ready_o, 0);
  endtask

  // R3: offered data while closed must not land in the buffer
  task automatic t_overflow();
    for (int k = 0; k < 3; k++) begin
      strm_valid_i = 1'b1;
      strm_data_i  = 32'hDEAD_0000 + k;
      @(negedge clk);
      chk(!strm_ready_o, "R3 stays closed", strm_ready_o, 0);
    end
    strm_valid_i = 1'b0;
  endtask

  task automatic t_write(input logic [31:0] base, input bit stall);
    logic [95:0] exp_d;
    logic [31:0] exp_a;
    write_i    = 1'b1;
    res_base_i = base;
    @(negedge clk);
    write_i    = 1'b0;
    res_base_i = 32'hFFFF_FFF0;
    for (int b = 0; b < 3; b++) begin
      exp_a = base + 32'(12 * b);
      exp_d = {exp_buf[3*b+2], exp_buf[3*b+1], exp_buf[3*b]};
      if (stall) begin
        mreq_ready_i = 1'b0;
        chk(mreq_valid_o, "R6 valid before stall", mreq_valid_o, 1);
        @(negedge clk);
        @(negedge clk);
        chk(mreq_valid_o && mreq_addr_o == exp_a, "R6 held during stall",
            {mreq_valid_o, mreq_addr_o}, {1'b1, exp_a});
      end
      mreq_ready_i = 1'b1;
      chk(mreq_valid_o && mreq_addr_o == exp_a, "R4 request address",
          {mreq_valid_o, mreq_addr_o}, {1'b1, exp_a});
      chk(mreq_data_o == exp_d, "R5 request data", mreq_data_o, exp_d);
      @(negedge clk);
      mreq_ready_i = 1'b0;
    end
    chk(!mreq_valid_o, "R4 only three requests", mreq_valid_o, 0);
    @(negedge clk);
    chk(!done_o, "R7 no done on requests", done_o, 0);
    for (int r = 0; r < 3; r++) begin
      mresp_valid_i = 1'b1;
      @(negedge clk);
      mresp_valid_i = 1'b0;
      if (r < 2) chk(!done_o, "R7 done early", done_o, 0);
      else       chk(done_o, "R7 done after third response", done_o, 1);
    end
    @(negedge clk);
    chk(!done_o, "R7 done single pulse", done_o, 0);
  endtask

  task automatic t_stray_resp();
    mresp_valid_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    mresp_valid_i = 1'b0;
    chk(!done_o, "R9 stray response ignored", done_o, 0);
    @(negedge clk);
    chk(!done_o && !mreq_valid_o, "R9 still idle", {done_o, mreq_valid_o}, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_stray_resp();
    t_collect(32'h1234_5678, 1'b0);
    t_overflow();
    t_write(32'h0000_1000, 1'b0);
    t_collect(32'hA5A5_0F0F, 1'b1);
    t_write(32'h8000_0040, 1'b1);
    t_stray_resp();
    finish_run();
  end
endmodule